// File: doc/BRIEF.md
# Serial Register Access Port

This block is the slave end of a serial configuration link. It gives a host read and write access to 256 byte-wide registers through four pins: an active-low select, a serial clock, a bidirectional data line and a dedicated data output. All four pins are sampled into the fast system clock and edge-detected there. Each access opens with a 16-bit instruction word that holds a direction flag, a two-bit length code and a 13-bit start address. Data bytes follow the instruction, and the register address moves by one after every byte. Register 0 is the port's own configuration register. Its bit 6 selects the bit order, least significant first or most significant first. Its bit 7 moves read data from the shared line to the dedicated output.

The protocol engine has four states. ST_IDLE waits for the select to be low. The first rising serial edge seen there is the START transition, which enters ST_INSTR, latches the bit order and takes in the first instruction bit. ST_INSTR collects the remaining 15 bits, and TO_DATA enters ST_DATA on the sixteenth bit. ST_DATA moves whole bytes. For a counted length, FINISH enters ST_DONE after the last byte, and ST_DONE ignores all further clocks. RELEASE returns from ST_DONE to ST_IDLE when the select goes high. ABORT returns from ST_INSTR or ST_DATA to ST_IDLE when the select rises at a point where a pause is not allowed. A select rise where a pause is allowed leaves every counter unchanged, and the access continues when the select falls again.

Top module: `spi_cfg_port`

## Requirements
- R1: After reset, all 256 registers read 0x00, the port is in most-significant-first, three-wire mode, dio_oe is low and dout is high.
- R2: Instruction bit 15 is the direction (1 = read, 0 = write), bits 14:13 are the length code and bits 12:0 are the start address. Only address bits 7:0 select a register, and bits 12:8 have no effect.
- R3: Length codes 00, 01 and 10 move exactly 1, 2 and 3 data bytes. Bytes clocked after that are not written, and read data is not driven for them (dio_oe low).
- R4: With register 0 bit 6 clear, every bit is sent and received most significant first, and the address goes up by one after each data byte.
- R5: With register 0 bit 6 set, the whole 16-bit instruction and each data byte travel least significant first, and the address goes down by one after each data byte. The order in effect at START holds for the whole access.
- R6: Length code 11 moves data bytes for as long as the select stays low.
- R7: For length codes 00 to 10, a select-high pause at any byte boundary, inside or after the instruction or between data bytes, keeps the access, and it resumes when the select falls again.
- R8: For length code 11, a pause at the instruction's middle boundary or before the first data bit is allowed. A select rise after the first data bit ends the access, and the next falling select starts a new instruction.
- R9: A select rise in the middle of any byte ends the access. A partly received write byte is never stored.
- R10: In three-wire mode, dio_oe is high only during the data phase of a read while the select is low, and it drops as soon as the select rises. Read bits change on falling serial edges.
- R11: With register 0 bit 7 set, read data comes out on dout, dio_oe stays low, and dout is high at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host, low while idle |
| dio_i | input | 1 | Input side of the bidirectional data line |
| dio_o | output | 1 | Output side of the bidirectional data line |
| dio_oe | output | 1 | Drive enable for the bidirectional data line |
| dout | output | 1 | Dedicated read-data output for four-wire mode |

## Verification
A wrong state or counter in this engine shows up at the ports within one byte. A length count that is off by one writes a register that a later read-back exposes. A wrong order flag or address step puts data at mirrored or shifted addresses. An ignored abort turns the next instruction's bits into register writes. A state machine that stays in or leaves ST_DATA at the wrong time shows on dio_oe within a few system clocks of the next falling serial edge. Because the read path is driven on the falling edge, a mistake there is visible at the next host sample point, half a serial period later.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INSTR = 2'd1,
        ST_DATA  = 2'd2,
        ST_DONE  = 2'd3
    } port_state_t;

    // Bit positions inside configuration register 0.
    localparam int CFG_LSB_BIT  = 6;
    localparam int CFG_4W_BIT   = 7;

    // Length code that requests an open-ended stream.
    localparam logic [1:0] LEN_STREAM = 2'b11;

endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic din,
    output logic cs_low,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic din_s
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] cs_q;
    logic [TOP:0] ck_q;
    logic [TOP:0] d_q;
    logic         ck_prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cs_q <= '1;
                    ck_q <= '0;
                    d_q  <= '0;
                end else begin
                    cs_q <= cs_n;
                    ck_q <= sclk;
                    d_q  <= din;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cs_q <= '1;
                    ck_q <= '0;
                    d_q  <= '0;
                end else begin
                    cs_q <= {cs_q[TOP-1:0], cs_n};
                    ck_q <= {ck_q[TOP-1:0], sclk};
                    d_q  <= {d_q[TOP-1:0], din};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ck_prev <= 1'b0;
        else        ck_prev <= ck_q[TOP];
    end

    assign cs_low    = ~cs_q[TOP];
    assign sclk_rise =  ck_q[TOP] & ~ck_prev;
    assign sclk_fall = ~ck_q[TOP] &  ck_prev;
    assign din_s     =  d_q[TOP];

endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
    import spi_cfg_pkg::*;
#(
    parameter int NREG   = 256,
    parameter int DATA_W = 8,
    parameter int AW     = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              lsb_first,
    output logic              four_wire
);
    logic [DATA_W-1:0] mem [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata     = mem[raddr];
    assign lsb_first = mem[0][CFG_LSB_BIT];
    assign four_wire = mem[0][CFG_4W_BIT];

endmodule

// File: rtl/spi_cfg_fsm.sv
module spi_cfg_fsm
    import spi_cfg_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int REG_AW = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_low,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              din,
    input  logic              lsb_cfg,
    input  logic [DATA_W-1:0] rdata,
    output logic              we,
    output logic [REG_AW-1:0] waddr,
    output logic [DATA_W-1:0] wdata,
    output logic [REG_AW-1:0] raddr,
    output logic              out_bit,
    output logic              rd_active,
    output port_state_t       state,
    output logic [ADDR_W-1:0] addr_q,
    output logic              lsb_q,
    output logic [1:0]        len_q
);
    localparam int INSTR_W  = ADDR_W + 3;
    localparam int CNT_W    = $clog2(INSTR_W);
    localparam int BYTE_LOG = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_INSTR = CNT_W'(INSTR_W - 1);
    localparam logic [CNT_W-1:0] LAST_DATA  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

    port_state_t          state_nx;
    logic [CNT_W-1:0]     bit_cnt;
    logic [INSTR_W-1:0]   shreg;
    logic [INSTR_W-1:0]   shift_nx;
    logic [DATA_W-1:0]    byte_nx;
    logic [1:0]           nbytes;
    logic                 rw_q;
    logic                 order_now;
    logic                 edge_ok;
    logic                 at_boundary;
    logic                 pause_ok;
    logic                 final_byte;
    logic                 byte_done;
    logic [BYTE_LOG-1:0]  bit_idx;

    // ---------------- shared decode ----------------
    always_comb begin
        order_now   = (state == ST_IDLE) ? lsb_cfg : lsb_q;
        shift_nx    = order_now ? {din, shreg[INSTR_W-1:1]}
                                : {shreg[INSTR_W-2:0], din};
        byte_nx     = order_now ? shift_nx[INSTR_W-1 -: DATA_W]
                                : shift_nx[DATA_W-1:0];
        edge_ok     = cs_low & sclk_rise;
        at_boundary = (bit_cnt[BYTE_LOG-1:0] == '0);
        final_byte  = (len_q != LEN_STREAM) && (nbytes == len_q);
        byte_done   = edge_ok && (state == ST_DATA) && (bit_cnt == LAST_DATA);
        bit_idx     = lsb_q ? bit_cnt[BYTE_LOG-1:0]
                            : BYTE_LOG'(DATA_W - 1) - bit_cnt[BYTE_LOG-1:0];
        unique case (state)
            ST_INSTR: pause_ok = at_boundary;
            ST_DATA:  pause_ok = at_boundary &&
                                 ((len_q != LEN_STREAM) || (nbytes == 2'd0));
            default:  pause_ok = 1'b1;
        endcase
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (edge_ok) state_nx = ST_INSTR;                      // START
            ST_INSTR: if (!cs_low && !pause_ok) state_nx = ST_IDLE;          // ABORT
                      else if (edge_ok && bit_cnt == LAST_INSTR)
                          state_nx = ST_DATA;                                 // TO_DATA
            ST_DATA:  if (!cs_low && !pause_ok) state_nx = ST_IDLE;          // ABORT
                      else if (byte_done && final_byte) state_nx = ST_DONE;   // FINISH
            ST_DONE:  if (!cs_low) state_nx = ST_IDLE;                       // RELEASE
            default:  state_nx = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            nbytes  <= '0;
            rw_q    <= 1'b0;
            len_q   <= '0;
            addr_q  <= '0;
            lsb_q   <= 1'b0;
            out_bit <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (edge_ok) begin
                    lsb_q   <= lsb_cfg;
                    shreg   <= shift_nx;
                    bit_cnt <= CNT_ONE;
                    nbytes  <= '0;
                end
                ST_INSTR: if (edge_ok) begin
                    shreg <= shift_nx;
                    if (bit_cnt == LAST_INSTR) begin
                        rw_q    <= shift_nx[INSTR_W-1];
                        len_q   <= shift_nx[INSTR_W-2 -: 2];
                        addr_q  <= shift_nx[ADDR_W-1:0];
                        bit_cnt <= '0;
                    end else begin
                        bit_cnt <= bit_cnt + CNT_ONE;
                    end
                end
                ST_DATA: begin
                    if (edge_ok) begin
                        shreg <= shift_nx;
                        if (bit_cnt == LAST_DATA) begin
                            bit_cnt <= '0;
                            addr_q  <= lsb_q ? addr_q - ADDR_W'(1) : addr_q + ADDR_W'(1);
                            if (nbytes != 2'd3) nbytes <= nbytes + 2'd1;
                        end else begin
                            bit_cnt <= bit_cnt + CNT_ONE;
                        end
                    end
                    if (cs_low && sclk_fall && rw_q) out_bit <= rdata[bit_idx];
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        we        = byte_done && !rw_q;
        waddr     = addr_q[REG_AW-1:0];
        wdata     = byte_nx;
        raddr     = addr_q[REG_AW-1:0];
        rd_active = (state == ST_DATA) && rw_q;
    end

endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
    import spi_cfg_pkg::*;
#(
    parameter int NREG        = 256,
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic dio_i,
    output logic dio_o,
    output logic dio_oe,
    output logic dout
);
    localparam int REG_AW = $clog2(NREG);

    logic              cs_low, sclk_rise, sclk_fall, din_s;
    logic              we, out_bit, rd_active;
    logic              lsb_first, four_wire, lsb_q;
    logic [REG_AW-1:0] waddr, raddr;
    logic [DATA_W-1:0] wdata, rdata;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        len_q;
    port_state_t       fsm_state;

    spi_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(dio_i),
        .cs_low(cs_low), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .din_s(din_s)
    );

    spi_cfg_fsm #(.ADDR_W(ADDR_W), .REG_AW(REG_AW), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_low(cs_low), .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall), .din(din_s), .lsb_cfg(lsb_first), .rdata(rdata),
        .we(we), .waddr(waddr), .wdata(wdata), .raddr(raddr), .out_bit(out_bit),
        .rd_active(rd_active), .state(fsm_state), .addr_q(addr_q), .lsb_q(lsb_q),
        .len_q(len_q)
    );

    spi_cfg_regs #(.NREG(NREG), .DATA_W(DATA_W), .AW(REG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rdata), .lsb_first(lsb_first), .four_wire(four_wire)
    );

    assign dio_o  = out_bit;
    assign dio_oe = ~cs_n & rd_active & ~four_wire;
    assign dout   = (four_wire && rd_active) ? out_bit : 1'b1;

endmodule

// File: rtl/spi_cfg_port_chk.sv
module spi_cfg_port_chk
    import spi_cfg_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              dio_oe,
    input logic              dout,
    input logic              four_wire,
    input logic              rd_active,
    input logic              we,
    input logic              lsb_q,
    input logic [ADDR_W-1:0] addr_q,
    input logic [1:0]        len_q,
    input port_state_t       state
);
    a_r10_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !dio_oe);

    a_r10_oe_in_read_data: assert property (@(posedge clk) disable iff (!rst_n)
        dio_oe |-> (state == ST_DATA));

    a_r11_no_oe_four_wire: assert property (@(posedge clk) disable iff (!rst_n)
        four_wire |-> !dio_oe);

    a_r11_dout_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !four_wire |-> dout);

    a_r4_addr_up: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !lsb_q) |=> (addr_q == ADDR_W'($past(addr_q) + ADDR_W'(1))));

    a_r5_addr_down: assert property (@(posedge clk) disable iff (!rst_n)
        (we && lsb_q) |=> (addr_q == ADDR_W'($past(addr_q) - ADDR_W'(1))));

    a_r6_stream_never_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |-> (len_q != LEN_STREAM));

    a_r3_done_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |-> (!dio_oe && dout));

endmodule

bind spi_cfg_port spi_cfg_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dio_oe(dio_oe), .dout(dout),
    .four_wire(four_wire), .rd_active(rd_active), .we(we), .lsb_q(lsb_q),
    .addr_q(addr_q), .len_q(len_q), .state(fsm_state)
);

// File: tb/test_spi_cfg_port.sv
module test_spi_cfg_port;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic dio_i = 1'b0;
    logic dio_o, dio_oe, dout;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] exp_mem [256];
    logic [7:0] tx_buf  [16];
    logic       lsb_now = 1'b0;
    logic       four_now = 1'b0;

    always #5 clk = ~clk;

    spi_cfg_port i_spi_cfg_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .dio_i(dio_i),
        .dio_o(dio_o), .dio_oe(dio_oe), .dout(dout)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        wait_half();
    endtask

    task automatic cs_hi();
        wait_half();
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 oe drops with select", {7'd0, dio_oe}, 8'd0);
        wait_half();
    endtask

    task automatic bit_io(input logic b, output logic r, output logic oe, output logic dq);
        dio_i = b;
        wait_half();
        r  = four_now ? dout : dio_o;
        oe = dio_oe;
        dq = dout;
        sclk = 1'b1;
        wait_half();
        sclk = 1'b0;
    endtask

    task automatic send_instr(input logic rw, input logic [1:0] len, input logic [12:0] a,
                              input bit pause_mid);
        logic [15:0] w;
        logic r, oe, dq;
        w = {rw, len, a};
        for (int i = 0; i < 16; i++) begin
            if (pause_mid && i == 8) begin
                cs_hi();
                cs_lo();
            end
            bit_io(w[lsb_now ? i : 15 - i], r, oe, dq);
            if (i == 15) chk("R10 oe low during instruction", {7'd0, oe}, 8'd0);
        end
    endtask

    task automatic xfer_byte(input logic [7:0] d, input logic rd_valid, input int nbits,
                             output logic [7:0] r);
        logic rb, oe, dq;
        r = '0;
        for (int i = 0; i < nbits; i++) begin
            int idx;
            idx = lsb_now ? i : 7 - i;
            bit_io(d[idx], rb, oe, dq);
            r[idx] = rb;
            chk(four_now ? "R11 oe stays low" : "R10/R3 oe in read data",
                {7'd0, oe}, {7'd0, rd_valid & ~four_now});
            if (!four_now) chk("R11 dout idle in three-wire", {7'd0, dq}, 8'd1);
        end
    endtask

    // pause_at: -1 none, 0 mid instruction, 1 after instruction, k+2 after data byte k
    task automatic txn(input string tag, input logic rw, input logic [1:0] len,
                       input logic [12:0] a, input int n, input int pause_at);
        logic [12:0] ad;
        logic [7:0]  r;
        int          cnt;
        lsb_now  = exp_mem[0][6];
        four_now = exp_mem[0][7];
        cnt = (len == 2'b11) ? 1000 : int'(len) + 1;
        ad = a;
        cs_lo();
        send_instr(rw, len, a, pause_at == 0);
        if (pause_at == 1) begin cs_hi(); cs_lo(); end
        for (int i = 0; i < n; i++) begin
            xfer_byte(tx_buf[i], rw && (i < cnt), 8, r);
            if (i < cnt) begin
                if (rw) chk(tag, r, exp_mem[ad[7:0]]);
                else    exp_mem[ad[7:0]] = tx_buf[i];
                ad = lsb_now ? ad - 13'd1 : ad + 13'd1;
            end
            if (pause_at == i + 2) begin cs_hi(); cs_lo(); end
        end
        cs_hi();
        four_now = exp_mem[0][7];
    endtask

    task automatic set_cfg(input logic [7:0] v);
        tx_buf[0] = v;
        txn("R4/R5 config write", 1'b0, 2'b00, 13'd0, 1, -1);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] r;
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 reset dio_oe", {7'd0, dio_oe}, 8'd0);
        chk("R1 reset dout", {7'd0, dout}, 8'd1);
        txn("R1 reset register value", 1'b1, 2'b10, 13'h005, 3, -1);

        // R2 direction, length, address; high address bits ignored
        tx_buf[0] = 8'hA5;
        txn("R2 write", 1'b0, 2'b00, 13'h010, 1, -1);
        txn("R2 read back", 1'b1, 2'b00, 13'h010, 1, -1);
        tx_buf[0] = 8'h3C;
        txn("R2 upper address write", 1'b0, 2'b00, 13'h1F40, 1, -1);
        txn("R2 upper address ignored", 1'b1, 2'b00, 13'h0040, 1, -1);
        txn("R2 alias read", 1'b1, 2'b00, 13'h0A40, 1, -1);

        // R3/R4/R5/R6 sweep over both orders and all length codes
        for (int ord = 0; ord < 2; ord++) begin
            set_cfg(ord ? 8'h40 : 8'h00);
            for (int len = 0; len < 4; len++) begin
                int nb;
                logic [12:0] base;
                nb = (len == 3) ? 5 : len + 1;
                base = 13'(8'h88 + ord * 8'h40 + len * 8'h10);
                for (int i = 0; i < nb + 1; i++)
                    tx_buf[i] = 8'(8'h11 * (i + 1) + ord * 8'h80 + len * 8'h04);
                txn(ord ? "R5 write" : "R4 write", 1'b0, 2'(len), base, nb + 1, -1);
                txn(len == 3 ? "R6 stream read" : "R3 count bound read",
                    1'b1, 2'b11, base, nb + 2, -1);
                txn("R3 counted read", 1'b1, 2'(len), base, nb + 1, -1);
            end
        end
        set_cfg(8'h00);

        // R7 pauses in counted transfers at every byte boundary
        for (int p = 0; p < 5; p++) begin
            for (int i = 0; i < 3; i++) tx_buf[i] = 8'(8'hC0 + p * 4 + i);
            txn("R7 paused write", 1'b0, 2'b10, 13'h060, 3, p);
            txn("R7 paused read", 1'b1, 2'b10, 13'h060, 3, p);
        end

        // R8 stream: pause before first data byte is allowed
        for (int i = 0; i < 3; i++) tx_buf[i] = 8'(8'h71 + i);
        txn("R8 allowed pause write", 1'b0, 2'b11, 13'h068, 3, 1);
        txn("R8 allowed pause mid instruction", 1'b1, 2'b11, 13'h068, 3, 0);

        // R8 stream: rise after first data byte aborts
        lsb_now = 1'b0;
        cs_lo();
        send_instr(1'b0, 2'b11, 13'h070, 1'b0);
        xfer_byte(8'h5A, 1'b0, 8, r);
        exp_mem[8'h70] = 8'h5A;
        cs_hi();
        cs_lo();
        send_instr(1'b1, 2'b00, 13'h0071, 1'b0);
        xfer_byte(8'h00, 1'b1, 8, r);
        chk("R8 abort then new instruction read", r, 8'h00);
        cs_hi();
        txn("R8 abort left next address untouched", 1'b1, 2'b01, 13'h070, 2, -1);

        // R9 mid-byte rise: partial write byte not stored
        cs_lo();
        send_instr(1'b0, 2'b00, 13'h075, 1'b0);
        xfer_byte(8'hFF, 1'b0, 4, r);
        cs_hi();
        txn("R9 partial byte discarded", 1'b1, 2'b00, 13'h075, 1, -1);
        cs_lo();
        send_instr(1'b0, 2'b00, 13'h075, 1'b0);
        xfer_byte(8'hF0, 1'b0, 8, r);
        xfer_byte(8'hFF, 1'b0, 3, r);
        exp_mem[8'h75] = 8'hF0;
        cs_hi();
        txn("R9 mid-byte rise in counted data", 1'b1, 2'b00, 13'h075, 1, -1);

        // R11 four-wire reads on dout
        set_cfg(8'h80);
        txn("R11 four-wire read", 1'b1, 2'b11, 13'h010, 3, -1);
        set_cfg(8'hC0);
        txn("R11 four-wire LSB read", 1'b1, 2'b01, 13'h060, 2, -1);
        set_cfg(8'h00);
        txn("R10 three-wire read restored", 1'b1, 2'b00, 13'h010, 1, -1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule